// File: doc/BRIEF.md
# Test Access Port with Shared Pin Ownership

This block is a boundary-scan test access port: a sixteen-state TAP controller, a 4-bit instruction register, a 1-bit bypass register and a small loopback data register. Around it sits an ownership stage. This stage decides whether the TCK, TDI and TDO pins belong to the scan logic or to ordinary user logic. A static strap input, `dedicated_mode`, picks between two behaviours. In dedicated operation the pins always belong to the scan port. In flexible operation, which is the default with the strap low, the scan port claims the pins only after a TCK rising edge seen while TMS is low. It hands them back as soon as the controller returns to Test-Logic-Reset.

All pins are plain level signals with no handshake. TCK is the only clock and `trst_n` is the only reset. While the user side owns the pins, its TDO drive and enable reach the pad unchanged, and the TCK and TDI pad levels are forwarded to the user. While the scan port owns the pins, the user side receives zeros.

Top module: `scan_port_share`

## Requirements
- R1: With `dedicated_mode`=1, `scan_owns` is 1 in every TAP state, including Test-Logic-Reset. With `dedicated_mode`=0 (flexible), `scan_owns` is 0 after reset.
- R2: In flexible mode, a TCK rising edge with TMS=0 while the pins are released sets `scan_owns` to 1 right after that edge.
- R3: In flexible mode, `scan_owns` returns to 0 on the TCK edge where the TAP enters Test-Logic-Reset. Five rising edges with TMS=1 reach that state from any state, so from Shift-DR the fourth edge still leaves the pins owned and the fifth releases them.
- R4: `trst_n`=0 asynchronously forces the TAP into Test-Logic-Reset, releases the pins in flexible mode, and sets the instruction register to 4'b1111.
- R5: The TAP follows the standard sixteen-state graph on rising TCK. TDO and its enable change only on falling TCK, so the enable is still 0 just after the edge that enters a shift state and goes to 1 after the following falling edge.
- R6: The instruction register is 4 bits wide and is shifted LSB first. It loads 4'b0001 in Capture-IR, takes the shifted value in Update-IR, and returns to 4'b1111 whenever the TAP is in Test-Logic-Reset.
- R7: Instruction 4'b1111 selects a 1-bit bypass register that captures 0, so shifted data comes out delayed by one bit.
- R8: Any other instruction selects a DR_W-bit (default 8) loopback register, shifted LSB first. It captures the value last written in Update-DR, and that value is 0 after reset.
- R9: While the scan port owns the pins, `pin_tdo_oe` is 1 only in Shift-IR and Shift-DR.
- R10: While the scan port does not own the pins, `pin_tdo`/`pin_tdo_oe` equal `usr_tdo`/`usr_tdo_oe`, and `user_tck_in`/`user_tdi_in` follow the TCK/TDI pins. While it owns them, both user inputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock pin, also a user input when released |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in pin, also a user input when released |
| trst_n | input | 1 | Asynchronous active-low TAP reset |
| dedicated_mode | input | 1 | Static strap: 1 dedicated, 0 flexible |
| usr_tdo | input | 1 | User drive value for the TDO pin |
| usr_tdo_oe | input | 1 | User output enable for the TDO pin |
| pin_tdo | output | 1 | Value driven on the TDO pad |
| pin_tdo_oe | output | 1 | Output enable of the TDO pad |
| user_tck_in | output | 1 | TCK pad level forwarded to user logic |
| user_tdi_in | output | 1 | TDI pad level forwarded to user logic |
| scan_owns | output | 1 | 1 while the pins belong to the scan port |

## Verification
The ownership logic is exercised with long runs of TMS high, which must leave the pins with the user while both user drive values toggle. A single TMS-low edge must claim the pins. A five-edge TMS-high exit from Shift-DR tells an off-by-one release apart from a correct one, and an asynchronous reset in the middle of a shift must release the pins without waiting for an edge. The data path is driven with distinct bit patterns through the instruction register, the bypass register and the loopback register. These show the one-bit bypass delay, the 0001 capture value and the Update-DR retention as separate results. A stale instruction after reset also leaves a different output pattern from bypass.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e state_nxt
);
  always_comb begin
    unique case (state)
      ST_TLR:    state_nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  state_nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: state_nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  state_nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: state_nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   state_nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= state_nxt;
  end

  // R5: TMS high holds the controller in Test-Logic-Reset
  a_r5_tlr_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR));
endmodule

// File: rtl/scan_regs.sv
module scan_regs
  import scan_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int DR_W = 8
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       tdo_q,
  output logic       tdo_oe_q
);
  localparam logic [IR_W-1:0] BYPASS_OP = {IR_W{1'b1}};
  localparam logic [IR_W-1:0] CAPT_VAL  = IR_W'(1);

  logic [IR_W-1:0] ir_sr, ir_q;
  logic [DR_W-1:0] dr_sr, dr_q;
  logic            byp_q;
  logic            byp_sel;

  assign byp_sel = (ir_q == BYPASS_OP);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
      ir_q  <= BYPASS_OP;
      dr_sr <= '0;
      dr_q  <= '0;
      byp_q <= 1'b0;
    end else begin
      unique case (state)
        ST_TLR:    ir_q  <= BYPASS_OP;
        ST_CAP_IR: ir_sr <= CAPT_VAL;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sr;
        ST_CAP_DR: if (byp_sel) byp_q <= 1'b0; else dr_sr <= dr_q;
        ST_SH_DR:  if (byp_sel) byp_q <= tdi;  else dr_sr <= {tdi, dr_sr[DR_W-1:1]};
        ST_UPD_DR: if (!byp_sel) dr_q <= dr_sr;
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q    <= 1'b0;
      tdo_oe_q <= 1'b0;
    end else begin
      tdo_oe_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR)  tdo_q <= ir_sr[0];
      else if (byp_sel)       tdo_q <= byp_q;
      else                    tdo_q <= dr_sr[0];
    end
  end

  // R9: the scan driver is enabled only in a shift state
  a_r9_oe_shift_only: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe_q |-> (state == ST_SH_IR || state == ST_SH_DR));
  // R6: capture loads the fixed pattern
  a_r6_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == CAPT_VAL));
  // R6: Test-Logic-Reset leaves the bypass instruction in place
  a_r6_tlr_bypass: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> byp_sel);
endmodule

// File: rtl/pin_owner.sv
module pin_owner
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       tdi,
  input  logic       dedicated_mode,
  input  tap_state_e state_nxt,
  input  logic       scan_tdo,
  input  logic       scan_tdo_oe,
  input  logic       usr_tdo,
  input  logic       usr_tdo_oe,
  output logic       pin_tdo,
  output logic       pin_tdo_oe,
  output logic       user_tck_in,
  output logic       user_tdi_in,
  output logic       owns
);
  logic claim_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      claim_q <= 1'b0;
    else if (claim_q) claim_q <= (state_nxt != ST_TLR);
    else              claim_q <= !tms;
  end

  assign owns        = dedicated_mode | claim_q;
  assign pin_tdo     = owns ? scan_tdo    : usr_tdo;
  assign pin_tdo_oe  = owns ? scan_tdo_oe : usr_tdo_oe;
  assign user_tck_in = owns ? 1'b0 : tck;
  assign user_tdi_in = owns ? 1'b0 : tdi;

  // R2: a TMS-low edge claims released pins
  a_r2_claim: assert property (@(posedge tck) disable iff (!trst_n)
    (!dedicated_mode && !claim_q && !tms) |=> claim_q);
endmodule

// File: rtl/scan_port_share.sv
module scan_port_share
  import scan_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int DR_W = 8
) (
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  input  logic trst_n,
  input  logic dedicated_mode,
  input  logic usr_tdo,
  input  logic usr_tdo_oe,
  output logic pin_tdo,
  output logic pin_tdo_oe,
  output logic user_tck_in,
  output logic user_tdi_in,
  output logic scan_owns
);
  tap_state_e state, state_nxt;
  logic       scan_tdo, scan_tdo_oe;
  logic       tap_tdi;

  assign tap_tdi = tdi & scan_owns;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms),
    .state(state), .state_nxt(state_nxt)
  );

  scan_regs #(.IR_W(IR_W), .DR_W(DR_W)) u_regs (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tap_tdi),
    .tdo_q(scan_tdo), .tdo_oe_q(scan_tdo_oe)
  );

  pin_owner u_own (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .dedicated_mode(dedicated_mode), .state_nxt(state_nxt),
    .scan_tdo(scan_tdo), .scan_tdo_oe(scan_tdo_oe),
    .usr_tdo(usr_tdo), .usr_tdo_oe(usr_tdo_oe),
    .pin_tdo(pin_tdo), .pin_tdo_oe(pin_tdo_oe),
    .user_tck_in(user_tck_in), .user_tdi_in(user_tdi_in),
    .owns(scan_owns)
  );

  // R3: in flexible mode the pins are free whenever the TAP rests in reset
  a_r3_release_in_tlr: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && !dedicated_mode) |-> !scan_owns);
  // R1: dedicated mode never gives the pins away
  a_r1_dedicated_owns: assert property (@(posedge tck) disable iff (!trst_n)
    dedicated_mode |-> scan_owns);
endmodule

// File: tb/tb_scan_port_share.sv
module tb_scan_port_share;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
  logic dedicated_mode = 1'b0, usr_tdo = 1'b0, usr_tdo_oe = 1'b0;
  logic pin_tdo, pin_tdo_oe, user_tck_in, user_tdi_in, scan_owns;
  logic seen_tdo, seen_oe;
  int checks = 0, fails = 0;

  always #4 tck = ~tck;

  scan_port_share dut (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
    .dedicated_mode(dedicated_mode), .usr_tdo(usr_tdo), .usr_tdo_oe(usr_tdo_oe),
    .pin_tdo(pin_tdo), .pin_tdo_oe(pin_tdo_oe), .user_tck_in(user_tck_in),
    .user_tdi_in(user_tdi_in), .scan_owns(scan_owns)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one TCK cycle: sample TDO after the falling edge, then drive inputs
  task automatic tick(input logic m, input logic d);
    @(negedge tck); #1;
    seen_tdo = pin_tdo; seen_oe = pin_tdo_oe;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic shift_ir(input logic [3:0] din, output logic [3:0] dout);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, din[i]);
      dout[i] = seen_tdo;
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [7:0] din, output logic [7:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      dout[i] = seen_tdo;
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic do_reset();
    @(negedge tck); trst_n = 1'b0; tms = 1'b1; #2;
    @(negedge tck); #1; trst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    #1;
    chk("R1 flexible reset owns", scan_owns, 0);
    usr_tdo = 1; usr_tdo_oe = 1; #1;
    chk("R10 reset passthrough tdo", {pin_tdo, pin_tdo_oe}, 2'b11);
    do_reset();
  endtask

  task automatic t_passthrough();
    for (int i = 0; i < 6; i++) begin
      usr_tdo = i[0]; usr_tdo_oe = i[1];
      tick(1, i[0]);
      chk("R10 tdo passthrough", {pin_tdo, pin_tdo_oe}, {i[0], i[1]});
      chk("R10 tdi forwarded", user_tdi_in, i[0]);
    end
    chk("R2 no claim with TMS high", scan_owns, 0);
  endtask

  task automatic t_claim();
    usr_tdo = 1; usr_tdo_oe = 1;
    tick(0, 1);
    chk("R2 claim after TMS low edge", scan_owns, 1);
    chk("R10 user tdi blocked", user_tdi_in, 0);
    @(negedge tck); #1;
    chk("R9 oe low in RTI", pin_tdo_oe, 0);
    chk("R10 user tck blocked", user_tck_in, 0);
  endtask

  task automatic t_ir_bypass();
    logic [3:0] o4;
    logic [7:0] o8;
    shift_ir(4'b1111, o4);
    chk("R6 IR capture 0001", o4, 4'b0001);
    shift_dr(4, 8'b1011, o8);
    chk("R7 bypass one-bit delay", o8[3:0], 4'b0110);
  endtask

  task automatic t_loopback();
    logic [3:0] o4;
    logic [7:0] o8;
    shift_ir(4'b0010, o4);
    chk("R6 IR capture again", o4, 4'b0001);
    shift_dr(8, 8'hA5, o8);
    chk("R8 loopback reset value", o8, 8'h00);
    shift_dr(8, 8'h3C, o8);
    chk("R8 loopback retains update", o8, 8'hA5);
  endtask

  task automatic t_oe_timing();
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R5 oe not yet on at rising edge", pin_tdo_oe, 0);
    @(negedge tck); #1;
    chk("R5 oe on after falling edge", pin_tdo_oe, 1);
    chk("R9 oe in Shift-DR", pin_tdo_oe, 1);
  endtask

  task automatic t_release();
    usr_tdo = 0; usr_tdo_oe = 1;
    for (int i = 0; i < 4; i++) tick(1, 0);
    chk("R3 still owned after four edges", scan_owns, 1);
    tick(1, 0);
    chk("R3 released on fifth edge", scan_owns, 0);
    chk("R10 user drive back", {pin_tdo, pin_tdo_oe}, 2'b01);
  endtask

  task automatic t_async_reset();
    logic [3:0] o4;
    logic [7:0] o8;
    tick(0, 0);
    shift_ir(4'b0010, o4);
    tick(1, 0); tick(0, 0); tick(0, 0);
    @(negedge tck); #2; trst_n = 1'b0; tms = 1'b1; #1;
    chk("R4 async release", scan_owns, 0);
    @(negedge tck); #1; trst_n = 1'b1;
    tick(0, 0);
    shift_dr(4, 8'b1011, o8);
    chk("R4 IR reset to bypass", o8[3:0], 4'b0110);
    for (int i = 0; i < 5; i++) tick(1, 0);
  endtask

  task automatic t_dedicated();
    @(negedge tck); trst_n = 1'b0; dedicated_mode = 1'b1; usr_tdo = 1; usr_tdo_oe = 1;
    @(negedge tck); #1; trst_n = 1'b1;
    tick(1, 0); tick(1, 0);
    chk("R1 dedicated owns in TLR", scan_owns, 1);
    chk("R9 dedicated oe low in TLR", pin_tdo_oe, 0);
    dedicated_mode = 1'b0;
    do_reset();
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog R1..R10 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_passthrough();
    t_claim();
    t_ir_bypass();
    t_loopback();
    t_oe_timing();
    t_release();
    t_async_reset();
    t_dedicated();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule